// File: doc/BRIEF.md
# Register-Mapped GPIO Controller with Pin Interrupts

This block is a bank of general-purpose I/O pins behind a plain 32-bit register port. Software selects the direction of each pin, reads the synchronised pin levels, and drives outputs through a write-one-to-set word and a write-one-to-clear word, so single pins can change without a read-modify-write sequence.

Every pin can also raise an interrupt. A type bit picks edge or level detection, and a polarity bit picks rising/high or falling/low. An enable bit decides whether the pin records events at all. A mask bit decides whether a recorded event reaches the one combined, registered interrupt output. Edge events stay latched in the pending word until software writes a 1 to acknowledge them. Level events track the pin.

The pin count (`PINS`, below 32) and the sense of the direction bits (`DIR_INV`) are fixed when the block is built. Reads come back one cycle after the read strobe.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After synchronous reset, every register reads 0, `pin_oe` and `pin_out` are 0, and `irq` is 0.
- R2: Register words sit at byte offsets: direction 0x00, input 0x04, output level 0x0C (read back), enable 0x14, type 0x18, polarity 0x1C, pending 0x20, mask 0x24. Reads of 0x08, 0x10, misaligned addresses or any offset above 0x24 return 0. Register bits at or above `PINS` read 0. `bus_rdata` shows the addressed word in the cycle after a cycle with `bus_rd` high, and 0 otherwise. Writes to the input word have no effect.
- R3: A write to 0x0C sets the outputs whose data bits are 1. A write to 0x10 clears the outputs whose data bits are 1. Zero bits leave their outputs unchanged.
- R4: With `DIR_INV`=0, `pin_oe` equals the direction word. With `DIR_INV`=1, it is the bitwise inverse of that word.
- R5: The input word returns `pin_in` after a two-flop synchroniser.
- R6: With type bit 0 (edge), polarity 1 detects a 0-to-1 change and polarity 0 detects a 1-to-0 change. A detected edge sets the pending bit, and the bit stays set after the pin returns.
- R7: Writing 1 to a pending bit of an edge-mode pin clears it. Zero bits, and bits of level-mode pins, are unaffected.
- R8: With type bit 1 (level), the pending bit is 1 exactly while the enable bit is 1 and the synchronised pin equals the polarity bit.
- R9: While a pin's enable bit is 0, its edges are not recorded.
- R10: `irq` is a register equal to the OR over pins of pending AND enable AND mask. A mask of 0 hides a pending bit from `irq` but does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | PINS | Pin levels, asynchronous |
| pin_out | output | PINS | Output levels |
| pin_oe | output | PINS | Output drive enables |
| irq | output | 1 | Combined interrupt, registered |

## Verification
On every cycle, the assertions check that a newly set pending bit had its enable bit set, and that an edge-mode pending bit drops only under an acknowledge write. They also check that `irq` rises only from an enabled, unmasked pending source, that set and clear writes take effect on `pin_out`, and that `bus_rdata` is 0 after idle cycles. Some behaviours are only shown by the bench's scenarios, which run against a reference model: the polarity choice for edges and levels, that edges stay latched after the pin returns, that masking keeps the pending bit, the inverted direction build, and the register address decode.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int DATA_W = 32;
  // byte offsets of the register words
  localparam logic [7:0] OFS_DIR  = 8'h00;
  localparam logic [7:0] OFS_IN   = 8'h04;
  localparam logic [7:0] OFS_SET  = 8'h0C;
  localparam logic [7:0] OFS_CLR  = 8'h10;
  localparam logic [7:0] OFS_IEN  = 8'h14;
  localparam logic [7:0] OFS_TYP  = 8'h18;
  localparam logic [7:0] OFS_POL  = 8'h1C;
  localparam logic [7:0] OFS_PEND = 8'h20;
  localparam logic [7:0] OFS_MSK  = 8'h24;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] q_now,
  output logic [W-1:0] q_prev
);
  localparam int DEPTH = STAGES + 1;
  logic [W-1:0] chain [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) chain[i] <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < DEPTH; i++) chain[i] <= chain[i-1];
    end
  end

  assign q_now  = chain[STAGES-1];
  assign q_prev = chain[STAGES];
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] smp_prev,
  input  logic [W-1:0] en,
  input  logic [W-1:0] lvl_mode,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] msk,
  input  logic [W-1:0] ack,
  output logic [W-1:0] pend_q,
  output logic         irq_q
);
  logic [W-1:0] pend_d;

  for (genvar g = 0; g < W; g++) begin : g_pin
    logic edge_hit, lvl_hit;
    assign edge_hit = (smp[g] & ~smp_prev[g] & pol[g]) |
                      (~smp[g] & smp_prev[g] & ~pol[g]);
    assign lvl_hit  = ~(smp[g] ^ pol[g]);
    assign pend_d[g] = lvl_mode[g] ? (en[g] & lvl_hit)
                                   : ((pend_q[g] & ~ack[g]) | (en[g] & edge_hit));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= |(pend_q & en & msk);
    end
  end

  AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    ((pend_q & ~$past(pend_q) & ~$past(en)) == '0)); // R9

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (|($past(pend_q) & ~pend_q & ~$past(lvl_mode) & $past(en))) |-> (|$past(ack))); // R7

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (|$past(pend_q & en & msk))); // R10
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int PINS    = 16,
  parameter bit DIR_INV = 1'b0,
  parameter int ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic              irq
);
  localparam int PAD = DATA_W - PINS;

  logic [PINS-1:0] dir_q, out_q, en_q, typ_q, pol_q, msk_q;
  logic [PINS-1:0] smp, smp_prev, pend, ack;
  logic [PINS-1:0] wd;
  logic [7:0]      ofs;
  logic wr_dir, wr_set, wr_clr, wr_ien, wr_typ, wr_pol, wr_pend, wr_msk;
  logic [31:0] rd_mux;
  logic unused_wdata_hi;

  assign wd  = bus_wdata[PINS-1:0];
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:PINS];
  assign ofs = 8'(bus_addr);

  assign wr_dir  = bus_wr && (ofs == OFS_DIR);
  assign wr_set  = bus_wr && (ofs == OFS_SET);
  assign wr_clr  = bus_wr && (ofs == OFS_CLR);
  assign wr_ien  = bus_wr && (ofs == OFS_IEN);
  assign wr_typ  = bus_wr && (ofs == OFS_TYP);
  assign wr_pol  = bus_wr && (ofs == OFS_POL);
  assign wr_pend = bus_wr && (ofs == OFS_PEND);
  assign wr_msk  = bus_wr && (ofs == OFS_MSK);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0; out_q <= '0; en_q <= '0;
      typ_q <= '0; pol_q <= '0; msk_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wd;
      if (wr_set) out_q <= out_q | wd;
      if (wr_clr) out_q <= out_q & ~wd;
      if (wr_ien) en_q  <= wd;
      if (wr_typ) typ_q <= wd;
      if (wr_pol) pol_q <= wd;
      if (wr_msk) msk_q <= wd;
    end
  end

  assign ack = wr_pend ? wd : '0;

  gpio_pin_sync #(.W(PINS), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .din(pin_in), .q_now(smp), .q_prev(smp_prev)
  );

  gpio_irq_unit #(.W(PINS)) u_irq (
    .clk(clk), .rst(rst), .smp(smp), .smp_prev(smp_prev), .en(en_q),
    .lvl_mode(typ_q), .pol(pol_q), .msk(msk_q), .ack(ack),
    .pend_q(pend), .irq_q(irq)
  );

  always_comb begin
    unique case (ofs)
      OFS_DIR:  rd_mux = {{PAD{1'b0}}, dir_q};
      OFS_IN:   rd_mux = {{PAD{1'b0}}, smp};
      OFS_SET:  rd_mux = {{PAD{1'b0}}, out_q};
      OFS_IEN:  rd_mux = {{PAD{1'b0}}, en_q};
      OFS_TYP:  rd_mux = {{PAD{1'b0}}, typ_q};
      OFS_POL:  rd_mux = {{PAD{1'b0}}, pol_q};
      OFS_PEND: rd_mux = {{PAD{1'b0}}, pend};
      OFS_MSK:  rd_mux = {{PAD{1'b0}}, msk_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end

  assign pin_out = out_q;

  if (DIR_INV) begin : g_oe_inv
    assign pin_oe = ~dir_q;
  end else begin : g_oe_dir
    assign pin_oe = dir_q;
  end

  AST_SET_DRIVES: assert property (@(posedge clk) disable iff (rst)
    $past(wr_set) |-> ((pin_out & $past(wd)) == $past(wd))); // R3

  AST_CLR_DRIVES: assert property (@(posedge clk) disable iff (rst)
    $past(wr_clr) |-> ((pin_out & $past(wd)) == '0)); // R3

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> (bus_rdata == '0)); // R2
endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;
  localparam int PINS = 12;
  localparam logic [31:0] M = (32'd1 << PINS) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic [PINS-1:0] pin_in = '0;
  logic [PINS-1:0] out_a, oe_a, out_b, oe_b;
  logic irq_a, irq_b;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  logic [31:0] m_dir, m_out, m_en, m_typ, m_pol, m_msk, m_pend, m_pin;

  always #5 clk = ~clk;

  gpio_irq_ctrl #(.PINS(PINS), .DIR_INV(1'b0), .ADDR_W(6)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .pin_in(pin_in),
    .pin_out(out_a), .pin_oe(oe_a), .irq(irq_a));

  gpio_irq_ctrl #(.PINS(PINS), .DIR_INV(1'b1), .ADDR_W(6)) dut_inv_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .pin_in(pin_in),
    .pin_out(out_b), .pin_oe(oe_b), .irq(irq_b));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model_fix();
    m_pend = ((m_pend & ~m_typ) | (m_typ & m_en & ~(m_pin ^ m_pol))) & M;
  endfunction

  function automatic void model_write(logic [7:0] a, logic [31:0] d);
    case (a)
      8'h00: m_dir = d & M;
      8'h0C: m_out = (m_out | d) & M;
      8'h10: m_out = m_out & ~d & M;
      8'h14: m_en  = d & M;
      8'h18: m_typ = d & M;
      8'h1C: m_pol = d & M;
      8'h20: m_pend = m_pend & ~(d & ~m_typ);
      8'h24: m_msk = d & M;
      default: ;
    endcase
    model_fix();
  endfunction

  function automatic void model_pins(logic [31:0] nv);
    logic [31:0] rise, fall;
    rise = nv & ~m_pin;
    fall = m_pin & ~nv;
    m_pend = m_pend | (((rise & m_pol) | (fall & ~m_pol)) & m_en & ~m_typ & M);
    m_pin = nv & M;
    model_fix();
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a);
    case (a)
      8'h00: return m_dir;
      8'h04: return m_pin;
      8'h0C: return m_out;
      8'h14: return m_en;
      8'h18: return m_typ;
      8'h1C: return m_pol;
      8'h20: return m_pend;
      8'h24: return m_msk;
      default: return 32'h0;
    endcase
  endfunction

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a[5:0]; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] da, output logic [31:0] db);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a[5:0];
    @(negedge clk);
    bus_rd = 1'b0;
    da = rdata_a; db = rdata_b;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic check_all();
    logic [31:0] ra, rb;
    logic [7:0] unused_ofs [6] = '{8'h08, 8'h10, 8'h28, 8'h2C, 8'h3C, 8'h0E};
    bus_read(8'h00, ra, rb); chk("R4 direction word", ra, exp_read(8'h00));
    bus_read(8'h04, ra, rb); chk("R5 input word", ra, exp_read(8'h04));
    bus_read(8'h0C, ra, rb); chk("R3 output word", ra, exp_read(8'h0C));
    bus_read(8'h14, ra, rb); chk("R2 enable word", ra, exp_read(8'h14));
    bus_read(8'h18, ra, rb); chk("R2 type word", ra, exp_read(8'h18));
    bus_read(8'h1C, ra, rb); chk("R2 polarity word", ra, exp_read(8'h1C));
    bus_read(8'h20, ra, rb); chk("R6/R7/R8/R9 pending word", ra, exp_read(8'h20));
    bus_read(8'h24, ra, rb); chk("R2 mask word", ra, exp_read(8'h24));
    bus_read(unused_ofs[$urandom_range(0, 5)], ra, rb); chk("R2 unused offset", ra, 32'h0);
    @(negedge clk);
    chk("R2 idle rdata", rdata_a, 32'h0);
    chk("R3 pin_out", 32'(out_a), m_out);
    chk("R4 pin_oe", 32'(oe_a), m_dir);
    chk("R4 inverted pin_oe", 32'(oe_b), ~m_dir & M);
    chk("R10 irq", 32'(irq_a), 32'(|(m_pend & m_en & m_msk)));
  endtask

  task automatic do_wr(logic [7:0] a, logic [31:0] d);
    bus_write(a, d);
    model_write(a, d);
    settle();
    check_all();
  endtask

  task automatic do_pin(logic [31:0] v);
    @(negedge clk);
    pin_in = v[PINS-1:0];
    model_pins(v);
    settle();
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    logic [7:0] waddr [9] = '{8'h00, 8'h04, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24};
    m_dir = 0; m_out = 0; m_en = 0; m_typ = 0; m_pol = 0; m_msk = 0; m_pend = 0; m_pin = 0;
    seed = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    @(negedge clk);
    chk("R1 irq after reset", 32'(irq_a), 32'h0);
    chk("R1 pin_oe after reset", 32'(oe_a), 32'h0);
    chk("R1 pin_out after reset", 32'(out_a), 32'h0);
    check_all();

    // R3 / R4 directed
    do_wr(8'h00, 32'hFFFF_F0F0);
    do_wr(8'h0C, 32'h0000_0A05);
    do_wr(8'h10, 32'h0000_0001);
    do_wr(8'h04, 32'hFFFF_FFFF);          // R2: input word not writable

    // R6: rising edge on pin 0, sticky
    do_wr(8'h1C, 32'h0000_0001);
    do_wr(8'h14, 32'h0000_0003);
    do_pin(32'h1);
    do_pin(32'h0);
    // R6: falling edge on pin 1 with polarity 0
    do_pin(32'h2);
    do_pin(32'h0);
    // R10: mask hides, pending kept
    do_wr(8'h24, 32'h0000_0001);
    do_wr(8'h24, 32'h0000_0000);
    do_wr(8'h24, 32'h0000_0003);
    // R7: acknowledge only pin 0, zero bits keep pin 1
    do_wr(8'h20, 32'h0000_0001);
    do_wr(8'h20, 32'h0000_0002);
    // R9: disabled pin ignores edges
    do_wr(8'h14, 32'h0000_0000);
    do_pin(32'h1);
    do_pin(32'h0);
    do_wr(8'h14, 32'h0000_0003);
    // R8: level mode on pin 2, active low then high
    do_wr(8'h18, 32'h0000_0004);
    do_wr(8'h14, 32'h0000_0004);
    do_pin(32'h4);
    do_wr(8'h1C, 32'h0000_0004);
    do_wr(8'h20, 32'h0000_0004);          // R7: no effect on level pin
    do_wr(8'h24, 32'h0000_0004);
    do_pin(32'h0);

    // constrained random mix
    for (int it = 0; it < 250; it++) begin
      int op;
      op = $urandom_range(0, 11);
      if (op < 9) do_wr(waddr[op], $urandom());
      else do_pin(32'(pin_in) ^ ($urandom() & M));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule